// File: doc/BRIEF.md
# Serial Transfer Clock Generator

This block makes the transfer-rate timing for one serial channel. It produces one-cycle enable pulses in the system clock domain, which the transmit and receive shifters use to advance. It does not produce derived clocks. An 8-bit divisor feeds a reloadable down-counter. That counter divides a count source, which is either one of four fixed prescaled taps of the system clock or the rising edges of an external clock pin. The pin is first passed through a synchronizer and an edge detector.

A post-divider follows the counter, and the mode picks its ratio. In clock-synchronous mode the counter output is halved. In UART mode the counter output is divided by sixteen, giving the usual sixteen-times oversampling rate. In clock-synchronous mode with the external source, the counter and the post-divider are skipped and every synchronized pin edge becomes a transfer pulse. The transmit and receive enables are identical.

Top module: `sio_clkgen`

## Requirements
- R1: With divisor value n (0 to 255), the counter emits one pulse for every n+1 count-source pulses. This holds at both ends of the range.
- R2: When the counter passes zero on a count-source pulse, it reloads from the reload register. The output period therefore repeats without drift.
- R3: A divisor write (div_we high) loads both the running counter and the reload register on the next clock. This happens while a transfer is running too. The write wins over a count-source pulse in the same cycle.
- R4: With src_sel set to 0, 1, 2 or 3, the internal count source is one pulse every 2, 16, 64 or 512 system clocks respectively.
- R5: In clock-synchronous mode (sync_mode=1) with the internal source (ext_sel=0), one transfer pulse comes out for every two counter pulses.
- R6: The external pin passes through a two-flop synchronizer and a rising-edge detector. With sync_mode=1 and ext_sel=1, each pin rising edge gives exactly one transfer pulse, and the counter is not used. With sync_mode=0 and ext_sel=1, the pin edges are the counter's count source.
- R7: In UART mode (sync_mode=0), one transfer pulse comes out for every sixteen counter pulses, and tx_tick and rx_tick are equal in every cycle.
- R8: Reset clears the counter, the reload register, the post-divider and the outputs to zero. Right after reset, UART mode with src_sel=0 therefore gives a period of 32 clocks.
- R9: A change of sync_mode, ext_sel or src_sel clears the post-divider phase. The first pulse after the change then needs a full set of counter pulses.
- R10: Every output pulse is one system clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_we | input | 1 | Divisor write strobe |
| div_wdata | input | 8 | Divisor value n |
| sync_mode | input | 1 | 1 = clock-synchronous mode, 0 = UART mode |
| ext_sel | input | 1 | 1 = external pin is the source |
| src_sel | input | 2 | Internal prescale tap: 0=/2, 1=/16, 2=/64, 3=/512 |
| ext_clk_in | input | 1 | External clock pin, asynchronous |
| tx_tick | output | 1 | Transmit transfer enable pulse |
| rx_tick | output | 1 | Receive transfer enable pulse |

## Verification
The bench measures the output period under divisors 0, 1, 3, 4 and 255, over all four prescale taps and in both modes. These runs separate the n+1 counter ratio from the /2 and /16 post-divider ratios and from the prescale ratio. A rewrite in the middle of a long period shows whether the running counter is loaded at once or only at its next reload. A source change soon after a pulse shows whether the post-divider phase is cleared. External-pin runs in both modes show whether the pin bypasses the counter or feeds it. Every cycle is also compared against a behavioural model.

// File: rtl/sio_clkgen_pkg.sv
package sio_clkgen_pkg;
    localparam int NUM_SRC  = 4;
    localparam int DIV_W    = 8;
    localparam int SYNC_DIV = 2;
    localparam int UART_DIV = 16;

    // log2 of the prescale ratio for each internal tap
    function automatic int src_shift(input int k);
        case (k)
            0:       return 1;
            1:       return 4;
            2:       return 6;
            default: return 9;
        endcase
    endfunction

    localparam int PRE_W = src_shift(NUM_SRC - 1);

    typedef struct packed {
        logic       sync_mode;
        logic       ext_sel;
        logic [1:0] src_sel;
    } cfg_t;
endpackage

// File: rtl/sio_prescaler.sv
module sio_prescaler
    import sio_clkgen_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    output logic [NUM_SRC-1:0] tap_tick
);
    logic [PRE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_tap
        localparam int SH = src_shift(k);
        assign tap_tick[k] = &cnt_q[SH-1:0];
    end
endmodule

// File: rtl/sio_edge_sync.sv
module sio_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = pin;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.s2 & ~st_q.s3;

    p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/sio_brg.sv
module sio_brg
    import sio_clkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_data,
    input  logic             src_tick,
    output logic             brg_tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] rel;
    } brg_t;

    brg_t st_d, st_q;
    logic expire;

    assign expire   = src_tick && !wr_en && (st_q.cnt == '0);
    assign brg_tick = expire;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cnt = wr_data;
            st_d.rel = wr_data;
        end else if (src_tick) begin
            if (st_q.cnt == '0) st_d.cnt = st_q.rel;
            else                st_d.cnt = st_q.cnt - DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_write_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.cnt == $past(wr_data)) && (st_q.rel == $past(wr_data)));
    p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        brg_tick |=> st_q.cnt == $past(st_q.rel));
    p_count_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (src_tick && !wr_en && st_q.cnt != '0) |=> st_q.cnt == $past(st_q.cnt) - DIV_W'(1));
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_tick && !wr_en) |=> $stable(st_q.cnt));
endmodule

// File: rtl/sio_postdiv.sv
module sio_postdiv
    import sio_clkgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_mode,
    input  logic cfg_chg,
    input  logic brg_tick,
    output logic out_tick
);
    localparam int PD_W = $clog2(UART_DIV);

    logic [PD_W-1:0] pd_d, pd_q;
    logic [PD_W-1:0] wrap;

    assign wrap     = sync_mode ? PD_W'(SYNC_DIV - 1) : PD_W'(UART_DIV - 1);
    assign out_tick = brg_tick && !cfg_chg && (pd_q == wrap);

    always_comb begin
        pd_d = pd_q;
        if (cfg_chg)       pd_d = '0;
        else if (brg_tick) pd_d = (pd_q == wrap) ? '0 : pd_q + PD_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pd_q <= '0;
        else        pd_q <= pd_d;
    end

    p_phase_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> pd_q == '0);
    p_sync_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && !cfg_chg && $past(sync_mode)) |-> pd_q <= PD_W'(SYNC_DIV - 1));
endmodule

// File: rtl/sio_clkgen.sv
module sio_clkgen
    import sio_clkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             sync_mode,
    input  logic             ext_sel,
    input  logic [1:0]       src_sel,
    input  logic             ext_clk_in,
    output logic             tx_tick,
    output logic             rx_tick
);
    typedef struct packed {
        cfg_t cfg;
        logic tick;
    } top_t;

    top_t st_d, st_q;
    cfg_t cfg_now;
    logic [NUM_SRC-1:0] tap_tick;
    logic ext_rise;
    logic src_tick;
    logic brg_tick;
    logic pd_tick;
    logic cfg_chg;
    logic bypass;

    assign cfg_now = '{sync_mode: sync_mode, ext_sel: ext_sel, src_sel: src_sel};
    assign cfg_chg = (cfg_now != st_q.cfg);
    assign bypass  = sync_mode && ext_sel;
    assign src_tick = ext_sel ? ext_rise : tap_tick[src_sel];

    sio_prescaler u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tap_tick (tap_tick)
    );

    sio_edge_sync u_ext (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_clk_in),
        .rise  (ext_rise)
    );

    sio_brg u_brg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (div_we),
        .wr_data  (div_wdata),
        .src_tick (src_tick),
        .brg_tick (brg_tick)
    );

    sio_postdiv u_pd (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_mode (sync_mode),
        .cfg_chg   (cfg_chg),
        .brg_tick  (brg_tick),
        .out_tick  (pd_tick)
    );

    always_comb begin
        st_d.cfg  = cfg_now;
        st_d.tick = bypass ? ext_rise : pd_tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_tick = st_q.tick;
    assign rx_tick = st_q.tick;

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick |=> !tx_tick);
    p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && $past(bypass) && tx_tick) |-> $past(ext_rise));
    p_uart_needs_brg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && !$past(sync_mode) && tx_tick) |-> $past(brg_tick));
endmodule

// File: tb/sio_clkgen_bench.sv
module sio_clkgen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_we = 1'b0;
    logic [7:0] div_wdata = 8'd0;
    logic       sync_mode = 1'b0;
    logic       ext_sel = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic       ext_clk_in = 1'b0;
    logic       tx_tick, rx_tick;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string phase = "R8";

    always #4 clk = ~clk;

    sio_clkgen u_sio_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_we     (div_we),
        .div_wdata  (div_wdata),
        .sync_mode  (sync_mode),
        .ext_sel    (ext_sel),
        .src_sel    (src_sel),
        .ext_clk_in (ext_clk_in),
        .tx_tick    (tx_tick),
        .rx_tick    (rx_tick)
    );

    // behavioural reference model
    int m_pre, m_s1, m_s2, m_s3, m_cnt, m_rel, m_pd, m_cfg, m_out;

    always @(posedge clk or negedge rst_n) begin
        int dv, src, brg, chg, wrap, fin, edg, cfgv, tap;
        if (!rst_n) begin
            m_pre = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_cnt = 0; m_rel = 0; m_pd = 0; m_cfg = 0; m_out = 0;
        end else begin
            case (src_sel)
                2'd0: dv = 2;
                2'd1: dv = 16;
                2'd2: dv = 64;
                default: dv = 512;
            endcase
            tap  = ((m_pre % dv) == dv - 1) ? 1 : 0;
            edg  = (m_s2 == 1 && m_s3 == 0) ? 1 : 0;
            src  = ext_sel ? edg : tap;
            brg  = (!div_we && src == 1 && m_cnt == 0) ? 1 : 0;
            cfgv = sync_mode * 8 + ext_sel * 4 + int'(src_sel);
            chg  = (cfgv != m_cfg) ? 1 : 0;
            wrap = sync_mode ? 1 : 15;
            if (sync_mode && ext_sel) fin = edg;
            else fin = (brg == 1 && chg == 0 && m_pd == wrap) ? 1 : 0;
            m_pre = (m_pre + 1) % 512;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk_in;
            if (div_we) begin
                m_cnt = div_wdata; m_rel = div_wdata;
            end else if (src == 1) begin
                m_cnt = (m_cnt == 0) ? m_rel : m_cnt - 1;
            end
            if (chg == 1) m_pd = 0;
            else if (brg == 1) m_pd = (m_pd == wrap) ? 0 : m_pd + 1;
            m_cfg = cfgv;
            m_out = fin;
        end
    end

    // lock-step comparison on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (tx_tick !== m_out[0] || rx_tick !== m_out[0]) begin
                errors++;
                $display("FAIL %s model compare: actual tx=%0b rx=%0b expected=%0b",
                         phase, tx_tick, rx_tick, m_out[0]);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_div(input int v);
        @(negedge clk);
        div_we = 1'b1;
        div_wdata = 8'(v);
        @(negedge clk);
        div_we = 1'b0;
    endtask

    task automatic wait_tick();
        int n = 0;
        while (!tx_tick && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic measure(output int per);
        wait_tick();
        @(negedge clk);
        per = 1;
        while (!tx_tick && per < 20000) begin
            @(negedge clk);
            per++;
        end
    endtask

    task automatic set_cfg(input bit sm, input bit es, input int sel);
        @(negedge clk);
        sync_mode = sm;
        ext_sel = es;
        src_sel = 2'(sel);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int p, p2, n, cnt;
        repeat (5) @(negedge clk);
        chk("R8 tx low in reset", int'(tx_tick), 0);
        chk("R8 rx low in reset", int'(rx_tick), 0);
        rst_n = 1'b1;

        phase = "R8";
        measure(p);
        chk("R8 period after reset (n=0,/2,UART)", p, 32);

        phase = "R1";
        wr_div(3);
        measure(p);
        chk("R1 R7 UART n=3 tap/2", p, 128);
        measure(p2);
        chk("R2 repeated period after reload", p2, 128);

        phase = "R4";
        set_cfg(0, 0, 1);
        wr_div(0);
        measure(p);
        chk("R4 UART tap/16 n=0", p, 256);
        set_cfg(0, 0, 2);
        wr_div(1);
        measure(p);
        chk("R4 UART tap/64 n=1", p, 2048);

        phase = "R5";
        set_cfg(1, 0, 3);
        wr_div(0);
        measure(p);
        chk("R5 R4 sync tap/512 n=0", p, 1024);
        set_cfg(1, 0, 1);
        wr_div(4);
        measure(p);
        chk("R5 sync tap/16 n=4", p, 160);
        set_cfg(1, 0, 0);
        wr_div(0);
        measure(p);
        chk("R5 R10 sync tap/2 n=0", p, 4);

        phase = "R1";
        set_cfg(0, 0, 0);
        wr_div(255);
        measure(p);
        chk("R1 UART n=255 tap/2", p, 8192);

        phase = "R3";
        wait_tick();
        repeat (100) @(negedge clk);
        wr_div(0);
        n = 0;
        while (!tx_tick && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk("R3 immediate counter load (tick within 40)", (n <= 40) ? 1 : 0, 1);

        phase = "R9";
        wait_tick();
        repeat (10) @(negedge clk);
        src_sel = 2'd1;
        n = 0;
        while (!tx_tick && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk("R9 full period after source change", (n >= 240 && n <= 257) ? 1 : 0, 1);

        phase = "R6";
        set_cfg(1, 1, 0);
        ext_clk_in = 1'b0;
        repeat (6) @(negedge clk);
        cnt = 0;
        for (int e = 0; e < 8; e++) begin
            ext_clk_in = 1'b1;
            repeat (5) begin @(negedge clk); if (tx_tick) cnt++; end
            ext_clk_in = 1'b0;
            repeat (5) begin @(negedge clk); if (tx_tick) cnt++; end
        end
        repeat (10) begin @(negedge clk); if (tx_tick) cnt++; end
        chk("R6 one tick per pin edge in sync bypass", cnt, 8);

        set_cfg(0, 1, 0);
        wr_div(1);
        cnt = 0;
        for (int e = 0; e < 160; e++) begin
            ext_clk_in = 1'b1;
            repeat (2) begin @(negedge clk); if (tx_tick) cnt++; end
            ext_clk_in = 1'b0;
            repeat (2) begin @(negedge clk); if (tx_tick) cnt++; end
        end
        chk("R6 UART counts pin edges (160 edges, n=1, /16)", cnt, 5);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule